// File: doc/BRIEF.md
# SEC-DED ECC Encoder and Syndrome Decoder for 64-bit Words

This block guards a 64-bit data word with an 8-bit check byte. Each check bit is the parity of the data word masked by one of eight fixed 64-bit masks. The masks do not follow Hamming order. The write channel accepts a data word and returns the same word with its check byte. The read channel accepts a captured word together with its captured check byte. It recomputes the check byte and forms the syndrome. It then classifies the result and returns the corrected word, a status code and the index of any failing bit.

A failing data bit is found by matching the syndrome against the mask column of every data bit. The syndrome is never read as a binary position. Only a syndrome that matches no column can be blamed on a check bit, and only when exactly one of its bits is set. Every other nonzero syndrome is reported as uncorrectable.

Both channels are streams with valid/ready and one register stage each. A channel accepts a word in any cycle where its output register is empty or the consumer takes the current output in that same cycle. While the consumer holds ready low, a pending output keeps its valid and its payload unchanged. The producer must then keep its word presented until the channel accepts it.

Top module: `ecc64_secded`

## Requirements
- R1: Check bit k equals the XOR-reduction of (data[63:32] AND H[k]) XOR (data[31:0] AND L[k]). The (H,L) pairs for k=0..7 are (f00fe11e,c33c0ff7), (00ff00ff,00fff0ff), (0f0f0f0f,0f0fff00), (11113333,7777000f), (22224444,8888222f), (44448888,ffff4441), (8888ffff,11118882) and (ffff1111,22221114).
- R2: Each channel has a latency of one cycle. A word accepted at a clock edge is presented with valid high right after that edge. Words leave in the order they were accepted.
- R3: A channel's in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid stays high and the payload stays unchanged.
- R4: The reported syndrome equals the check byte recomputed from the captured data, XORed with the captured check byte.
- R5: A zero syndrome gives status 0 (clean). The data passes through unchanged and both index flags are low.
- R6: Data bit n has a syndrome column whose bit k is L[k] bit n for n<32, and H[k] bit (n-32) for n>=32. A syndrome equal to the column of bit n gives status 1. The data index is n with its flag high, and the output data has bit n inverted. A column match takes precedence over every other rule.
- R7: A nonzero syndrome that matches no column and has exactly one bit set gives status 2. The check index is the position of that bit with its flag high, and the data passes through unchanged.
- R8: Any other nonzero syndrome gives status 3 (uncorrectable). Both index flags are low and the data passes through unchanged.
- R9: While reset is asserted, and right after it, both output valids are low.
- R10: The two index flags are never high together. An index field whose flag is low reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Write word presented |
| enc_in_ready | output | 1 | Write channel can accept |
| enc_in_data | input | 64 | Word to protect |
| enc_out_valid | output | 1 | Protected word available |
| enc_out_ready | input | 1 | Consumer takes protected word |
| enc_out_data | output | 64 | Protected word |
| enc_out_check | output | 8 | Computed check byte |
| dec_in_valid | input | 1 | Captured word presented |
| dec_in_ready | output | 1 | Read channel can accept |
| dec_in_data | input | 64 | Captured data |
| dec_in_check | input | 8 | Captured check byte |
| dec_out_valid | output | 1 | Decode result available |
| dec_out_ready | input | 1 | Consumer takes decode result |
| dec_out_data | output | 64 | Corrected data |
| dec_out_syndrome | output | 8 | Syndrome |
| dec_out_status | output | 2 | 0 clean, 1 data bit fixed, 2 check bit bad, 3 uncorrectable |
| dec_out_data_idx | output | 7 | Failing data bit index |
| dec_out_data_idx_vld | output | 1 | Data index valid |
| dec_out_chk_idx | output | 7 | Failing check bit index |
| dec_out_chk_idx_vld | output | 1 | Check index valid |

## Verification
The assertions watch every cycle for stall behaviour: a pending output must keep its valid and its payload while ready is low. They also check that a located data error changes exactly one bit of the word, and that a check-bit verdict leaves the data alone and carries a single-bit syndrome. Finally, they check that an uncorrectable verdict raises no index flag and that the two flags never coincide. Whether the mask columns steer each of the 72 single-bit faults to the right index and verdict can only be shown by the bench's scenarios. The same holds for multi-bit faults being classed as the requirements order, and for words staying in order under random back-pressure. For these the bench drives the data and compares the results against its own reference.

// File: rtl/ecc64_pkg.sv
package ecc64_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CHK_W  = 8;
  localparam int unsigned IDX_W  = 7;

  // Combined parity masks: upper half applies to data[63:32], lower to data[31:0].
  localparam logic [DATA_W-1:0] PARITY_MASK [CHK_W] = '{
    64'hf00fe11e_c33c0ff7,
    64'h00ff00ff_00fff0ff,
    64'h0f0f0f0f_0f0fff00,
    64'h11113333_7777000f,
    64'h22224444_8888222f,
    64'h44448888_ffff4441,
    64'h8888ffff_11118882,
    64'hffff1111_22221114
  };

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'd0,
    ST_DATA_FIX  = 2'd1,
    ST_CHECK_BAD = 2'd2,
    ST_UNCORR    = 2'd3
  } ecc_status_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CHK_W-1:0]  syndrome;
    ecc_status_e       status;
    logic [IDX_W-1:0]  data_idx;
    logic              data_idx_vld;
    logic [IDX_W-1:0]  chk_idx;
    logic              chk_idx_vld;
  } dec_result_t;

  // Syndrome produced by a flip of data bit n.
  function automatic logic [CHK_W-1:0] bit_column(input int n);
    logic [CHK_W-1:0] col;
    for (int k = 0; k < CHK_W; k++) col[k] = PARITY_MASK[k][n];
    return col;
  endfunction
endpackage

// File: rtl/ecc64_stage.sv
module ecc64_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) out_data <= in_data;
  end

  p_hold_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  p_hold_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));
endmodule

// File: rtl/ecc64_encoder.sv
module ecc64_encoder
  import ecc64_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] check
);
  for (genvar k = 0; k < CW; k++) begin : g_parity
    assign check[k] = ^(data & PARITY_MASK[k]);
  end
endmodule

// File: rtl/ecc64_decoder.sv
module ecc64_decoder
  import ecc64_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] check,
  output dec_result_t   result
);
  logic [CW-1:0] recalc;
  logic [CW-1:0] syn;
  logic [DW-1:0] hit;
  logic          data_hit;
  logic [IW-1:0] d_idx;
  logic [IW-1:0] c_idx;
  logic          single;

  ecc64_encoder #(.DW(DW), .CW(CW)) u_recalc (.data(data), .check(recalc));

  assign syn = recalc ^ check;

  for (genvar n = 0; n < DW; n++) begin : g_col
    localparam logic [CW-1:0] COL = bit_column(n);
    assign hit[n] = (syn == COL);
  end

  always_comb begin
    data_hit = 1'b0;
    d_idx    = '0;
    for (int n = DW - 1; n >= 0; n--) begin
      if (hit[n]) begin
        data_hit = 1'b1;
        d_idx    = IW'(n);
      end
    end
    c_idx = '0;
    for (int k = CW - 1; k >= 0; k--) begin
      if (syn[k]) c_idx = IW'(k);
    end
  end

  assign single = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    result              = '0;
    result.data         = data;
    result.syndrome     = syn;
    if (syn == '0) begin
      result.status = ST_CLEAN;
    end else if (data_hit) begin
      result.status       = ST_DATA_FIX;
      result.data_idx     = d_idx;
      result.data_idx_vld = 1'b1;
      result.data         = data ^ (DW'(1) << d_idx);
    end else if (single) begin
      result.status      = ST_CHECK_BAD;
      result.chk_idx     = c_idx;
      result.chk_idx_vld = 1'b1;
    end else begin
      result.status = ST_UNCORR;
    end
  end
endmodule

// File: rtl/ecc64_secded.sv
module ecc64_secded
  import ecc64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [DATA_W-1:0] enc_out_data,
  output logic [CHK_W-1:0]  enc_out_check,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [DATA_W-1:0] dec_in_data,
  input  logic [CHK_W-1:0]  dec_in_check,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic [CHK_W-1:0]  dec_out_syndrome,
  output logic [1:0]        dec_out_status,
  output logic [IDX_W-1:0]  dec_out_data_idx,
  output logic              dec_out_data_idx_vld,
  output logic [IDX_W-1:0]  dec_out_chk_idx,
  output logic              dec_out_chk_idx_vld
);
  localparam int unsigned ENC_W = DATA_W + CHK_W;
  localparam int unsigned DEC_W = $bits(dec_result_t);

  // Write channel
  logic [CHK_W-1:0] enc_chk;
  ecc64_encoder u_enc (.data(enc_in_data), .check(enc_chk));

  ecc64_stage #(.W(ENC_W)) u_enc_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready),
    .in_data({enc_in_data, enc_chk}),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready),
    .out_data({enc_out_data, enc_out_check})
  );

  // Read channel
  dec_result_t dec_res;
  dec_result_t dec_q;
  ecc64_decoder u_dec (.data(dec_in_data), .check(dec_in_check), .result(dec_res));

  ecc64_stage #(.W(DEC_W)) u_dec_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready),
    .in_data(dec_res),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready),
    .out_data(dec_q)
  );

  assign dec_out_data         = dec_q.data;
  assign dec_out_syndrome     = dec_q.syndrome;
  assign dec_out_status       = dec_q.status;
  assign dec_out_data_idx     = dec_q.data_idx;
  assign dec_out_data_idx_vld = dec_q.data_idx_vld;
  assign dec_out_chk_idx      = dec_q.chk_idx;
  assign dec_out_chk_idx_vld  = dec_q.chk_idx_vld;

  p_fix_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid && dec_res.data_idx_vld |-> $countones(dec_res.data ^ dec_in_data) == 1);
  p_check_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid && dec_res.status == ST_CHECK_BAD
      |-> dec_res.data == dec_in_data && $countones(dec_res.syndrome) == 1);
  p_uncorr_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid && dec_res.status == ST_UNCORR
      |-> !dec_res.data_idx_vld && !dec_res.chk_idx_vld && dec_res.data == dec_in_data);
  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> !(dec_out_data_idx_vld && dec_out_chk_idx_vld));
endmodule

// File: tb/ecc64_secded_bench.sv
module ecc64_secded_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        enc_in_valid = 1'b0, enc_out_ready = 1'b1;
  logic [63:0] enc_in_data = '0;
  logic        enc_in_ready, enc_out_valid;
  logic [63:0] enc_out_data;
  logic [7:0]  enc_out_check;
  logic        dec_in_valid = 1'b0, dec_out_ready = 1'b1;
  logic [63:0] dec_in_data = '0;
  logic [7:0]  dec_in_check = '0;
  logic        dec_in_ready, dec_out_valid;
  logic [63:0] dec_out_data;
  logic [7:0]  dec_out_syndrome;
  logic [1:0]  dec_out_status;
  logic [6:0]  dec_out_data_idx, dec_out_chk_idx;
  logic        dec_out_data_idx_vld, dec_out_chk_idx_vld;

  ecc64_secded u_ecc64_secded (.*);

  int n_chk = 0, n_err = 0;
  bit stall = 0, enc_acc = 0, dec_acc = 0;

  logic [31:0] hi_m [8] = '{32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
                            32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111};
  logic [31:0] lo_m [8] = '{32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
                            32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114};

  typedef struct packed {
    logic [63:0] data; logic [7:0] syn; logic [1:0] st;
    logic [6:0] didx; logic dv; logic [6:0] cidx; logic cv;
  } exp_dec_t;

  logic [71:0] enc_q [$];
  exp_dec_t    dec_q [$];

  function automatic logic [7:0] ref_check(logic [63:0] d);
    logic [7:0] c = '0;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 32; b++)
        c[k] = c[k] ^ (d[b] & lo_m[k][b]) ^ (d[b+32] & hi_m[k][b]);
    return c;
  endfunction

  function automatic logic [7:0] ref_col(int n);
    logic [7:0] c;
    for (int k = 0; k < 8; k++) c[k] = (n < 32) ? lo_m[k][n] : hi_m[k][n-32];
    return c;
  endfunction

  function automatic exp_dec_t ref_decode(logic [63:0] d, logic [7:0] c);
    exp_dec_t e = '0;
    int found = -1;
    e.data = d;
    e.syn  = ref_check(d) ^ c;
    for (int n = 0; n < 64; n++) if (found < 0 && ref_col(n) == e.syn) found = n;
    if (e.syn == 0) e.st = 2'd0;
    else if (found >= 0) begin
      e.st = 2'd1; e.didx = 7'(found); e.dv = 1'b1; e.data[found] = ~d[found];
    end else if ($countones(e.syn) == 1) begin
      e.st = 2'd2; e.cv = 1'b1;
      for (int k = 7; k >= 0; k--) if (e.syn[k]) e.cidx = 7'(k);
    end else e.st = 2'd3;
    return e;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string st_tag(logic [1:0] s);
    case (s) 2'd0: return "R5"; 2'd1: return "R6"; 2'd2: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic compare();
    exp_dec_t e;
    string t;
    chk("R3", enc_in_ready, enc_q.size() == 0 || enc_out_ready);
    chk("R3", dec_in_ready, dec_q.size() == 0 || dec_out_ready);
    chk("R2", enc_out_valid, enc_q.size() > 0);
    chk("R2", dec_out_valid, dec_q.size() > 0);
    if (enc_q.size() > 0) begin
      chk("R2", enc_out_data, enc_q[0][71:8]);
      chk("R1", enc_out_check, enc_q[0][7:0]);
    end
    if (dec_q.size() > 0) begin
      e = dec_q[0];
      t = st_tag(e.st);
      chk("R4", dec_out_syndrome, e.syn);
      chk(t, dec_out_status, e.st);
      chk(t, dec_out_data, e.data);
      chk(e.dv ? "R6" : "R10", {dec_out_data_idx_vld, dec_out_data_idx}, {e.dv, e.didx});
      chk(e.cv ? "R7" : "R10", {dec_out_chk_idx_vld, dec_out_chk_idx}, {e.cv, e.cidx});
    end
  endtask

  task automatic step();
    enc_out_ready = stall ? 1'($urandom % 2) : 1'b1;
    dec_out_ready = stall ? 1'($urandom % 2) : 1'b1;
    @(posedge clk);
    enc_acc = enc_in_valid && (enc_q.size() == 0 || enc_out_ready);
    dec_acc = dec_in_valid && (dec_q.size() == 0 || dec_out_ready);
    if (enc_q.size() > 0 && enc_out_ready) void'(enc_q.pop_front());
    if (dec_q.size() > 0 && dec_out_ready) void'(dec_q.pop_front());
    if (enc_acc) enc_q.push_back({enc_in_data, ref_check(enc_in_data)});
    if (dec_acc) dec_q.push_back(ref_decode(dec_in_data, dec_in_check));
    @(negedge clk);
    compare();
  endtask

  task automatic send_enc(logic [63:0] d);
    enc_in_valid = 1'b1; enc_in_data = d;
    do step(); while (!enc_acc);
    enc_in_valid = 1'b0;
  endtask

  task automatic send_dec(logic [63:0] d, logic [7:0] c);
    dec_in_valid = 1'b1; dec_in_data = d; dec_in_check = c;
    do step(); while (!dec_acc);
    dec_in_valid = 1'b0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic drain();
    stall = 0;
    repeat (3) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", enc_out_valid, 1'b0);
    chk("R9", dec_out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", {enc_out_valid, dec_out_valid}, 2'b00);

    // R1: walking ones, extremes, random words; R3 under random stalls
    send_enc('0);
    send_enc('1);
    for (int b = 0; b < 64; b++) send_enc(64'd1 << b);
    stall = 1;
    for (int i = 0; i < 40; i++) send_enc(rnd64());
    drain();

    // R5: clean words
    send_dec('0, ref_check('0));
    send_dec('1, ref_check('1));
    stall = 1;
    for (int i = 0; i < 16; i++) begin
      logic [63:0] d = rnd64();
      send_dec(d, ref_check(d));
    end
    // R6 / R7: every single-bit fault over all 72 positions
    for (int r = 0; r < 3; r++)
      for (int p = 0; p < 72; p++) begin
        logic [63:0] d = rnd64();
        logic [7:0]  c = ref_check(d);
        if (p < 64) d[p] = ~d[p]; else c[p-64] = ~c[p-64];
        send_dec(d, c);
      end
    // R8: double and triple faults
    for (int i = 0; i < 60; i++) begin
      logic [71:0] w;
      int a = $urandom % 72;
      int b = (a + 1 + ($urandom % 71)) % 72;
      w = {rnd64(), 8'h00};
      w[7:0] = ref_check(w[71:8]);
      w[a] = ~w[a];
      w[b] = ~w[b];
      if (i % 3 == 0) w[(b + 5) % 72] = ~w[(b + 5) % 72];
      send_dec(w[71:8], w[7:0]);
    end
    drain();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule